// File: doc/BRIEF.md
# Flash In-System Programming Command Controller

This block lets a processor read, program and page-erase a word-organized embedded flash through five registers on a simple synchronous bus. Software loads a target byte address, a data word and a six-bit command, then writes 1 to a start bit. The controller checks the request against its permission bits and the legal address windows. It then drives a timed strobe towards the flash array and clears the start bit when the operation ends. Any refused request sets a sticky fail flag. The flag stays set until software writes 1 to it.

Program and erase pulses last for a number of clock cycles. That number is the time selected by a three-bit code times the parameter `CYC_PER_US`, the count of clocks per microsecond. The two code tables are not monotonic. The array itself is outside the block. It is 16K words of 32 bits in 128-word pages, and there is also a small configuration area. A read returns the addressed word one cycle after the read strobe. Program ANDs the data into the addressed word. Erase sets every word of a page, or of the whole configuration area, to all ones. The company and device ID values are parameters.

Top module: `flash_isp`

## Requirements
- R1: After reset, all five registers read as zero and no flash strobe is active.
- R2: Register offsets are control 0x00, address 0x04, data 0x08, command 0x0C and trigger 0x10. Control keeps only these bits: 0 (enable), 1 (write permit), 4 (configuration permit), 10:8 (program time code) and 14:12 (erase time code). Bit 6 reads the fail flag. The command register keeps 6 bits. All other bits and offsets read zero.
- R3: Writing 1 to trigger bit 0 sets it. The bit reads 1 until the operation ends and then clears by itself. While it is 1, writes to the address, data, command and trigger registers are ignored.
- R4: Command 0x00 raises the read strobe for one cycle. The word the array returns is loaded into the data register two cycles after that strobe begins, and the trigger clears at the same edge.
- R5: Command 0x21 raises the program strobe, with the data register as write data. The strobe lasts T x CYC_PER_US cycles, where T in microseconds is 40, 45, 50, 55, 20, 25, 30 or 35 for time codes 0 to 7.
- R6: Command 0x22 raises the erase strobe for T x 1000 x CYC_PER_US cycles, where T in milliseconds is 20, 25, 30, 35, 3, 5, 10 or 15 for codes 0 to 7. The page that holds the address is erased, and other pages keep their contents.
- R7: Command 0x0B loads the company ID parameter into the data register. Command 0x0C loads the device ID parameter. The trigger clears one cycle after it was set.
- R8: A command whose bits 5:4 are 11 is standby. The trigger clears one cycle after it was set, and nothing else changes.
- R9: A program or erase started while the write permit bit is 0 raises no strobe. It sets the fail flag, and the trigger clears one cycle after it was set.
- R10: The same abort happens in each of these cases: the enable bit is 0, the command is undefined, the address has bits 1:0 not equal to 00, or the address lies outside both windows. The main window is bytes 0 to 0xFFFF. The configuration window is CFG_WORDS words at CFG_BASE.
- R11: The fail flag stays set when control is written with bit 6 equal to 0. It clears when control is written with bit 6 equal to 1.
- R12: With the configuration permit bit set, read, program and erase reach the configuration window, and the configuration select output is asserted for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Register byte offset |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| flashRead | output | 1 | Read strobe towards the array |
| flashProg | output | 1 | Program pulse |
| flashErase | output | 1 | Erase pulse |
| flashCfg | output | 1 | Selects the configuration area |
| flashAddr | output | 14 | Word address |
| flashWdata | output | 32 | Program data |
| flashRdata | input | 32 | Word returned by the array, registered on the read strobe |

## Verification
The assertions assume that software does not rewrite the control register while an operation runs. Under that assumption, the permit bits seen when a pulse begins are the bits that were checked one cycle earlier. The assertions also assume that the array only answers reads and never holds the controller busy. The stimulus writes control only while the trigger reads 0. It polls the trigger until it clears before every new step, and its array model returns a registered word on each read strobe.

// File: rtl/flash_isp_pkg.sv
`timescale 1ns/1ps
package flash_isp_pkg;
  localparam logic [4:0] OFS_CTRL = 5'h00;
  localparam logic [4:0] OFS_ADDR = 5'h04;
  localparam logic [4:0] OFS_DATA = 5'h08;
  localparam logic [4:0] OFS_CMD  = 5'h0C;
  localparam logic [4:0] OFS_TRIG = 5'h10;
  localparam int FAIL_BIT = 6;

  localparam logic [5:0] CMD_READ  = 6'h00;
  localparam logic [5:0] CMD_PROG  = 6'h21;
  localparam logic [5:0] CMD_ERASE = 6'h22;
  localparam logic [5:0] CMD_CID   = 6'h0B;
  localparam logic [5:0] CMD_DID   = 6'h0C;

  typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_RD_ISSUE, ST_RD_WAIT} seqStateT;

  // strobes from sequencer to register datapath
  typedef struct packed {
    logic setFail;
    logic clearGo;
    logic loadFlash;
    logic loadCid;
    logic loadDid;
  } seqStrobeT;

  // program time in microseconds: codes 4..7 are the short range
  function automatic logic [31:0] progMicros(input logic [2:0] code);
    logic [31:0] step;
    step = 32'(code[1:0]) * 32'd5;
    return code[2] ? 32'd20 + step : 32'd40 + step;
  endfunction

  // erase time in milliseconds
  function automatic logic [31:0] eraseMillis(input logic [2:0] code);
    logic [31:0] val;
    if (!code[2]) val = 32'd20 + 32'(code[1:0]) * 32'd5;
    else begin
      case (code[1:0])
        2'd0:    val = 32'd3;
        2'd1:    val = 32'd5;
        2'd2:    val = 32'd10;
        default: val = 32'd15;
      endcase
    end
    return val;
  endfunction
endpackage

// File: rtl/flash_isp_regs.sv
`timescale 1ns/1ps
module flash_isp_regs
  import flash_isp_pkg::*;
#(
  parameter logic [31:0] COMPANY_ID = 32'h0000_00DA,
  parameter logic [31:0] DEVICE_ID  = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  busAddr,
  input  logic        busWr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  seqStrobeT   strobe,
  input  logic [31:0] flashRdata,
  output logic        ctrlEn,
  output logic        ctrlEwen,
  output logic        ctrlCfgEn,
  output logic [2:0]  ptCode,
  output logic [2:0]  etCode,
  output logic [31:0] ispAddr,
  output logic [31:0] ispData,
  output logic [5:0]  ispCmd,
  output logic        goBit
);
  logic failFlag;
  logic wrCtrl, wrAddr, wrData, wrCmd, wrTrig;

  assign wrCtrl = busWr && (busAddr == OFS_CTRL);
  assign wrAddr = busWr && !goBit && (busAddr == OFS_ADDR);
  assign wrData = busWr && !goBit && (busAddr == OFS_DATA);
  assign wrCmd  = busWr && !goBit && (busAddr == OFS_CMD);
  assign wrTrig = busWr && !goBit && (busAddr == OFS_TRIG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn    <= 1'b0;
      ctrlEwen  <= 1'b0;
      ctrlCfgEn <= 1'b0;
      ptCode    <= '0;
      etCode    <= '0;
      failFlag  <= 1'b0;
      ispAddr   <= '0;
      ispData   <= '0;
      ispCmd    <= '0;
      goBit     <= 1'b0;
    end else begin
      if (wrCtrl) begin
        ctrlEn    <= busWdata[0];
        ctrlEwen  <= busWdata[1];
        ctrlCfgEn <= busWdata[4];
        ptCode    <= busWdata[10:8];
        etCode    <= busWdata[14:12];
      end
      if (strobe.setFail) failFlag <= 1'b1;
      else if (wrCtrl && busWdata[FAIL_BIT]) failFlag <= 1'b0;
      if (strobe.clearGo) goBit <= 1'b0;
      else if (wrTrig && busWdata[0]) goBit <= 1'b1;
      if (wrAddr) ispAddr <= busWdata;
      if (wrCmd) ispCmd <= busWdata[5:0];
      if (strobe.loadFlash) ispData <= flashRdata;
      else if (strobe.loadCid) ispData <= COMPANY_ID;
      else if (strobe.loadDid) ispData <= DEVICE_ID;
      else if (wrData) ispData <= busWdata;
    end
  end

  always_comb begin
    case (busAddr)
      OFS_CTRL: busRdata = {17'd0, etCode, 1'b0, ptCode, 1'b0, failFlag, 1'b0,
                            ctrlCfgEn, 2'b00, ctrlEwen, ctrlEn};
      OFS_ADDR: busRdata = ispAddr;
      OFS_DATA: busRdata = ispData;
      OFS_CMD:  busRdata = {26'd0, ispCmd};
      OFS_TRIG: busRdata = {31'd0, goBit};
      default:  busRdata = '0;
    endcase
  end

  // R11: fail flag survives everything except a write-1 to its bit
  assert_fail_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    failFlag && !(busWr && busAddr == OFS_CTRL && busWdata[FAIL_BIT]) |=> failFlag);
  // R3: running operation holds the trigger until the sequencer ends it
  assert_go_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    goBit && !strobe.clearGo |=> goBit);
  // R3: address frozen while busy
  assert_addr_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    goBit |=> $stable(ispAddr));
endmodule

// File: rtl/flash_isp_seq.sv
`timescale 1ns/1ps
module flash_isp_seq
  import flash_isp_pkg::*;
#(
  parameter int          CYC_PER_US = 50,
  parameter int          MAIN_WORDS = 16384,
  parameter logic [31:0] CFG_BASE   = 32'h0030_0000,
  parameter int          CFG_WORDS  = 2,
  localparam int         WA_W       = $clog2(MAIN_WORDS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            goBit,
  input  logic            ctrlEn,
  input  logic            ctrlEwen,
  input  logic            ctrlCfgEn,
  input  logic [2:0]      ptCode,
  input  logic [2:0]      etCode,
  input  logic [31:0]     ispAddr,
  input  logic [5:0]      ispCmd,
  output seqStrobeT       strobe,
  output logic            flashRead,
  output logic            flashProg,
  output logic            flashErase,
  output logic            flashCfg,
  output logic [WA_W-1:0] flashAddr
);
  localparam logic [31:0] MAIN_BYTES = 32'(MAIN_WORDS * 4);
  localparam logic [31:0] CFG_END    = CFG_BASE + 32'(CFG_WORDS * 4);

  seqStateT    state;
  logic [31:0] cnt;
  logic        opErase;
  logic isRead, isProg, isErase, isCid, isDid, isStby, known;
  logic inMain, inCfg, needsAddr, addrOk, fault;
  logic [31:0] progCycles, eraseCycles;

  assign isRead  = ispCmd == CMD_READ;
  assign isProg  = ispCmd == CMD_PROG;
  assign isErase = ispCmd == CMD_ERASE;
  assign isCid   = ispCmd == CMD_CID;
  assign isDid   = ispCmd == CMD_DID;
  assign isStby  = ispCmd[5:4] == 2'b11;
  assign known   = isRead || isProg || isErase || isCid || isDid || isStby;

  assign inMain    = ispAddr < MAIN_BYTES;
  assign inCfg     = (ispAddr >= CFG_BASE) && (ispAddr < CFG_END);
  assign needsAddr = isRead || isProg || isErase;
  assign addrOk    = (ispAddr[1:0] == 2'b00) && (inMain || (inCfg && ctrlCfgEn));
  assign fault     = !ctrlEn || !known || (needsAddr && !addrOk) ||
                     ((isProg || isErase) && !ctrlEwen);

  assign progCycles  = progMicros(ptCode) * 32'(CYC_PER_US);
  assign eraseCycles = eraseMillis(etCode) * 32'd1000 * 32'(CYC_PER_US);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      opErase <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (goBit && !fault) begin
          if (isRead) state <= ST_RD_ISSUE;
          else if (isProg) begin
            state <= ST_PULSE; cnt <= progCycles - 32'd1; opErase <= 1'b0;
          end else if (isErase) begin
            state <= ST_PULSE; cnt <= eraseCycles - 32'd1; opErase <= 1'b1;
          end
        end
        ST_PULSE: begin
          if (cnt == '0) state <= ST_IDLE;
          else cnt <= cnt - 32'd1;
        end
        ST_RD_ISSUE: state <= ST_RD_WAIT;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE: if (goBit) begin
        if (fault) begin
          strobe.setFail = 1'b1;
          strobe.clearGo = 1'b1;
        end else if (isCid) begin
          strobe.loadCid = 1'b1; strobe.clearGo = 1'b1;
        end else if (isDid) begin
          strobe.loadDid = 1'b1; strobe.clearGo = 1'b1;
        end else if (isStby) strobe.clearGo = 1'b1;
      end
      ST_PULSE:   strobe.clearGo = (cnt == '0);
      ST_RD_WAIT: begin strobe.loadFlash = 1'b1; strobe.clearGo = 1'b1; end
      default: ;
    endcase
  end

  assign flashRead  = state == ST_RD_ISSUE;
  assign flashProg  = (state == ST_PULSE) && !opErase;
  assign flashErase = (state == ST_PULSE) && opErase;
  assign flashCfg   = inCfg;
  assign flashAddr  = ispAddr[WA_W+1:2];

  // R5: at most one flash strobe at a time
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flashRead, flashProg, flashErase}));
  // R3: strobes only while trigger reads busy
  assert_strobe_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (flashRead || flashProg || flashErase) |-> goBit);
  // R10: only aligned words reach the array
  assert_aligned_R10: assert property (@(posedge clk) disable iff (!rstN)
    (flashRead || flashProg || flashErase) |-> ispAddr[1:0] == 2'b00);
  // R9: a pulse starts only after permission was present
  assert_permit_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashProg || flashErase) |-> $past(ctrlEwen && ctrlEn));
  // R9: an abort releases the trigger at the next edge
  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setFail |=> !goBit);
endmodule

// File: rtl/flash_isp.sv
`timescale 1ns/1ps
module flash_isp
  import flash_isp_pkg::*;
#(
  parameter int          CYC_PER_US = 50,
  parameter int          MAIN_WORDS = 16384,
  parameter logic [31:0] CFG_BASE   = 32'h0030_0000,
  parameter int          CFG_WORDS  = 2,
  parameter logic [31:0] COMPANY_ID = 32'h0000_00DA,
  parameter logic [31:0] DEVICE_ID  = 32'h0000_0001,
  localparam int         WA_W       = $clog2(MAIN_WORDS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [4:0]      busAddr,
  input  logic            busWr,
  input  logic [31:0]     busWdata,
  output logic [31:0]     busRdata,
  output logic            flashRead,
  output logic            flashProg,
  output logic            flashErase,
  output logic            flashCfg,
  output logic [WA_W-1:0] flashAddr,
  output logic [31:0]     flashWdata,
  input  logic [31:0]     flashRdata
);
  seqStrobeT   strobe;
  logic        ctrlEn, ctrlEwen, ctrlCfgEn, goBit;
  logic [2:0]  ptCode, etCode;
  logic [31:0] ispAddr, ispData;
  logic [5:0]  ispCmd;

  flash_isp_regs #(.COMPANY_ID(COMPANY_ID), .DEVICE_ID(DEVICE_ID)) regs_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .strobe(strobe), .flashRdata(flashRdata),
    .ctrlEn(ctrlEn), .ctrlEwen(ctrlEwen), .ctrlCfgEn(ctrlCfgEn),
    .ptCode(ptCode), .etCode(etCode), .ispAddr(ispAddr), .ispData(ispData),
    .ispCmd(ispCmd), .goBit(goBit));

  flash_isp_seq #(.CYC_PER_US(CYC_PER_US), .MAIN_WORDS(MAIN_WORDS),
                  .CFG_BASE(CFG_BASE), .CFG_WORDS(CFG_WORDS)) seq_i (
    .clk(clk), .rstN(rstN), .goBit(goBit), .ctrlEn(ctrlEn), .ctrlEwen(ctrlEwen),
    .ctrlCfgEn(ctrlCfgEn), .ptCode(ptCode), .etCode(etCode), .ispAddr(ispAddr),
    .ispCmd(ispCmd), .strobe(strobe), .flashRead(flashRead), .flashProg(flashProg),
    .flashErase(flashErase), .flashCfg(flashCfg), .flashAddr(flashAddr));

  assign flashWdata = ispData;
endmodule

// File: tb/flash_isp_tb_top.sv
`timescale 1ns/1ps
module flash_isp_tb_top;
  localparam int          CYC   = 1;
  localparam logic [31:0] CFGB  = 32'h0030_0000;
  localparam logic [31:0] CIDV  = 32'h0000_00DA;
  localparam logic [31:0] DIDV  = 32'h0057_2064;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = 5'h10;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        flashRead, flashProg, flashErase, flashCfg;
  logic [13:0] flashAddr;
  logic [31:0] flashWdata;
  logic [31:0] flashRdata = '0;

  int checks = 0, failures = 0, cyc = 0;
  int progHi = 0, eraseHi = 0, readHi = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_isp #(.CYC_PER_US(CYC), .CFG_BASE(CFGB), .CFG_WORDS(2),
              .COMPANY_ID(CIDV), .DEVICE_ID(DIDV)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .flashRead(flashRead), .flashProg(flashProg),
    .flashErase(flashErase), .flashCfg(flashCfg), .flashAddr(flashAddr),
    .flashWdata(flashWdata), .flashRdata(flashRdata));

  // behavioural flash array: absent entry means erased
  logic [31:0] fMain [int];
  logic [31:0] fCfg  [int];
  logic progPrev = 0, erasePrev = 0;

  always @(posedge clk) begin
    int idx;
    idx = flashCfg ? int'(flashAddr[0]) : int'(flashAddr);
    if (flashRead)
      flashRdata <= flashCfg ? (fCfg.exists(idx) ? fCfg[idx] : 32'hFFFF_FFFF)
                             : (fMain.exists(idx) ? fMain[idx] : 32'hFFFF_FFFF);
    if (flashProg && !progPrev) begin
      if (flashCfg) fCfg[idx] = (fCfg.exists(idx) ? fCfg[idx] : 32'hFFFF_FFFF) & flashWdata;
      else fMain[idx] = (fMain.exists(idx) ? fMain[idx] : 32'hFFFF_FFFF) & flashWdata;
    end
    if (flashErase && !erasePrev) begin
      if (flashCfg) fCfg.delete();
      else for (int i = 0; i < 128; i++) fMain.delete((idx & ~127) + i);
    end
    progPrev  <= flashProg;
    erasePrev <= flashErase;
  end

  // reference model
  int ptTab [8] = '{40, 45, 50, 55, 20, 25, 30, 35};
  int etTab [8] = '{20, 25, 30, 35, 3, 5, 10, 15};
  logic [31:0] mMain [int];
  logic [31:0] mCfg  [int];
  logic [31:0] mCtrl = 0, mAddr = 0, mData = 0;
  logic [5:0]  mCmd = 0;
  bit mFail = 0, mGo = 0, mErase = 0;
  int mSt = 0, mCnt = 0;

  function automatic bit mIsCfg();
    return mAddr >= CFGB && mAddr < CFGB + 32'd8;
  endfunction

  function automatic int mIdx();
    return mIsCfg() ? int'((mAddr - CFGB) >> 2) : int'(mAddr >> 2);
  endfunction

  function automatic logic [31:0] mGet();
    if (mIsCfg()) return mCfg.exists(mIdx()) ? mCfg[mIdx()] : 32'hFFFF_FFFF;
    return mMain.exists(mIdx()) ? mMain[mIdx()] : 32'hFFFF_FFFF;
  endfunction

  function automatic bit mFaulty();
    bit known, needs, wr, okAddr;
    wr    = (mCmd == 6'h21) || (mCmd == 6'h22);
    needs = wr || (mCmd == 6'h00);
    known = needs || mCmd == 6'h0B || mCmd == 6'h0C || mCmd[5:4] == 2'b11;
    okAddr = mAddr[1:0] == 2'b00 && ((mAddr < 32'h1_0000) || (mIsCfg() && mCtrl[4]));
    return !mCtrl[0] || !known || (needs && !okAddr) || (wr && !mCtrl[1]);
  endfunction

  always @(posedge clk) begin
    logic [31:0] nCtrl, nAddr, nData;
    logic [5:0] nCmd;
    bit nFail, nGo;
    if (!rstN) begin
      mCtrl = 0; mAddr = 0; mData = 0; mCmd = 0; mFail = 0; mGo = 0; mSt = 0; mCnt = 0;
    end else begin
      nCtrl = mCtrl; nAddr = mAddr; nData = mData; nCmd = mCmd; nFail = mFail; nGo = mGo;
      if (busWr) begin
        case (busAddr)
          5'h00: begin nCtrl = busWdata & 32'h0000_7713; if (busWdata[6]) nFail = 0; end
          5'h04: if (!mGo) nAddr = busWdata;
          5'h08: if (!mGo) nData = busWdata;
          5'h0C: if (!mGo) nCmd = busWdata[5:0];
          5'h10: if (!mGo && busWdata[0]) nGo = 1;
          default: ;
        endcase
      end
      case (mSt)
        0: if (mGo) begin
          if (mFaulty()) begin nFail = 1; nGo = 0; end
          else if (mCmd == 6'h00) mSt = 2;
          else if (mCmd == 6'h21) begin
            if (mIsCfg()) mCfg[mIdx()] = mGet() & mData; else mMain[mIdx()] = mGet() & mData;
            mSt = 1; mErase = 0; mCnt = ptTab[mCtrl[10:8]] * CYC - 1;
          end else if (mCmd == 6'h22) begin
            if (mIsCfg()) mCfg.delete();
            else for (int i = 0; i < 128; i++) mMain.delete((mIdx() & ~127) + i);
            mSt = 1; mErase = 1; mCnt = etTab[mCtrl[14:12]] * 1000 * CYC - 1;
          end else if (mCmd == 6'h0B) begin nData = CIDV; nGo = 0; end
          else if (mCmd == 6'h0C) begin nData = DIDV; nGo = 0; end
          else nGo = 0;
        end
        1: if (mCnt == 0) begin mSt = 0; nGo = 0; end else mCnt--;
        2: mSt = 3;
        default: begin nData = mGet(); nGo = 0; mSt = 0; end
      endcase
      mCtrl = nCtrl; mAddr = nAddr; mData = nData; mCmd = nCmd; mFail = nFail; mGo = nGo;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of the selected register and the strobes
  always @(negedge clk) begin
    #1;
    if (rstN && !finished) begin
      logic [31:0] exp;
      string tag;
      case (busAddr)
        5'h00: begin exp = mCtrl | (32'(mFail) << 6); tag = "R2 ctrl"; end
        5'h04: begin exp = mAddr; tag = "R2 addr"; end
        5'h08: begin exp = mData; tag = "R4 data"; end
        5'h0C: begin exp = {26'd0, mCmd}; tag = "R2 cmd"; end
        5'h10: begin exp = {31'd0, mGo}; tag = "R3 trigger"; end
        default: begin exp = 0; tag = "R2 hole"; end
      endcase
      chk({"per-cycle ", tag}, busRdata, exp);
      chk("per-cycle R5 strobes", {29'd0, flashRead, flashProg, flashErase},
          {29'd0, 1'(mSt == 2), 1'(mSt == 1 && !mErase), 1'(mSt == 1 && mErase)});
      if (flashProg) progHi++;
      if (flashErase) eraseHi++;
      if (flashRead) readHi++;
    end
  end

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1;
    @(negedge clk); busWr = 0; busAddr = 5'h10;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); busAddr = a; #1 v = busRdata;
  endtask

  task automatic waitIdle();
    busAddr = 5'h10;
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk); #1;
      if (busRdata[0] == 1'b0) return;
    end
    chk("R3 trigger never cleared", 32'd1, 32'd0);
  endtask

  task automatic runOp(input logic [5:0] cmd, input logic [31:0] addr);
    busWrite(5'h04, addr);
    busWrite(5'h0C, {26'd0, cmd});
    progHi = 0; eraseHi = 0; readHi = 0;
    busWrite(5'h10, 32'd1);
    waitIdle();
  endtask

  task automatic expectFault(input string tag);
    logic [31:0] v;
    busRead(5'h00, v);
    chk(tag, {31'd0, v[6]}, 32'd1);
    busWrite(5'h00, v | 32'h40);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rstN = 1;
    // R1 reset values
    for (int a = 0; a <= 16; a += 4) begin
      busRead(5'(a), v); chk("R1 reset register", v, 32'd0);
    end
    // R2 masks and offsets
    busWrite(5'h00, 32'hFFFF_FFFF); busRead(5'h00, v); chk("R2 ctrl mask", v, 32'h0000_7713);
    busWrite(5'h0C, 32'hFFFF_FFFF); busRead(5'h0C, v); chk("R2 cmd width", v, 32'h3F);
    busWrite(5'h08, 32'hA5A5_0001); busRead(5'h08, v); chk("R2 data", v, 32'hA5A5_0001);
    busRead(5'h14, v); chk("R2 unused offset", v, 32'd0);
    // R9 program without write permit
    busWrite(5'h00, 32'h0000_4001);
    runOp(6'h21, 32'h100);
    chk("R9 no program pulse", progHi, 0);
    busRead(5'h00, v); chk("R9 fail set", v, 32'h0000_4041);
    // R11 sticky flag
    busWrite(5'h00, 32'h0000_4003); busRead(5'h00, v); chk("R11 write0 keeps", v, 32'h0000_4043);
    busWrite(5'h00, 32'h0000_4043); busRead(5'h00, v); chk("R11 write1 clears", v, 32'h0000_4003);
    // R5 program, code 0 then 4 then 7
    busWrite(5'h08, 32'hF0F0_FFFF); runOp(6'h21, 32'h100); chk("R5 code0 40us", progHi, 40);
    busWrite(5'h00, 32'h0000_4403);
    busWrite(5'h08, 32'h0FFF_00FF); runOp(6'h21, 32'h100); chk("R5 code4 20us", progHi, 20);
    runOp(6'h00, 32'h100); busRead(5'h08, v); chk("R4 read anded word", v, 32'h00F0_00FF);
    chk("R4 single read strobe", readHi, 1);
    // R3 writes ignored while busy
    busWrite(5'h00, 32'h0000_4703);
    busWrite(5'h08, 32'h1234_5678);
    busWrite(5'h04, 32'h400);
    busWrite(5'h0C, 32'h21);
    progHi = 0;
    busWrite(5'h10, 32'd1);
    busRead(5'h10, v); chk("R3 busy reads 1", v, 32'd1);
    busWrite(5'h08, 32'h0000_DEAD);
    busWrite(5'h04, 32'h800);
    waitIdle();
    chk("R5 code7 35us", progHi, 35);
    busRead(5'h08, v); chk("R3 data write ignored", v, 32'h1234_5678);
    busRead(5'h04, v); chk("R3 addr write ignored", v, 32'h400);
    runOp(6'h00, 32'h800); busRead(5'h08, v); chk("R4 erased word", v, 32'hFFFF_FFFF);
    // R6 erase page 0, ET code 4
    runOp(6'h22, 32'h104); chk("R6 code4 3ms", eraseHi, 3000);
    runOp(6'h00, 32'h100); busRead(5'h08, v); chk("R6 page erased", v, 32'hFFFF_FFFF);
    runOp(6'h00, 32'h400); busRead(5'h08, v); chk("R6 other page kept", v, 32'h1234_5678);
    // R7 ID reads
    runOp(6'h0B, 32'h0); busRead(5'h08, v); chk("R7 company id", v, CIDV);
    runOp(6'h0C, 32'h0); busRead(5'h08, v); chk("R7 device id", v, DIDV);
    // R8 standby
    runOp(6'h35, 32'h0); busRead(5'h08, v); chk("R8 standby data", v, DIDV);
    busRead(5'h00, v); chk("R8 standby no fail", {31'd0, v[6]}, 32'd0);
    // R10 aborts
    runOp(6'h00, 32'h102); expectFault("R10 misaligned");
    runOp(6'h00, 32'h1_0000); expectFault("R10 out of range");
    runOp(6'h00, CFGB); expectFault("R10 cfg without permit");
    runOp(6'h05, 32'h0); expectFault("R10 undefined command");
    busWrite(5'h00, 32'h0000_4702);
    runOp(6'h35, 32'h0); expectFault("R10 disabled");
    // R12 configuration window
    busWrite(5'h00, 32'h0000_4713);
    busWrite(5'h08, 32'hCAFE_0000); runOp(6'h21, CFGB + 32'd4);
    chk("R12 cfg program pulse", progHi, 35);
    runOp(6'h00, CFGB + 32'd4); busRead(5'h08, v); chk("R12 cfg readback", v, 32'hCAFE_0000);
    runOp(6'h00, CFGB); busRead(5'h08, v); chk("R12 cfg other word", v, 32'hFFFF_FFFF);
    runOp(6'h00, CFGB + 32'd8); expectFault("R10 past cfg window");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule